// File: doc/BRIEF.md
# Queued-Operation SPI Flash Sequencer

This block is a single-lane SPI master that software drives entirely through a small set of word registers. Every bus action is written as an operation word and queued: raising or lowering the chip select, shifting a run of bytes out, or shifting a run of bytes in. A sequencer takes the words one at a time, in the order they were queued, and carries each one out.

Byte data travels through a separate byte-wide data queue. Software fills it with bytes for transmit runs. Receive runs fill it with captured bytes, which software then takes one at a time: it reads the head register and writes a pop strobe. The sequencer only fetches operations while the manual-enable bit is set. A 4-bit state code lets software see when the sequencer is idle.

Typical use is a command frame: lower the chip select, send the opcode and address bytes, receive or send data, then raise the chip select. Runs longer than the 9-bit length field can hold are split over several operations.

Top module: `opseq_top`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and spi_mosi is 0. Both queue-empty status bits read 1, both queue-full status bits read 0, and the state code reads 0.
- R2: Writing the staging register (address 0x2) holds an operation word. Bits [8:0] of the word are the byte count (0 to 511) and bits [13:9] are the operation code. Writing 1 in bit 0 of the commit register (0x3) queues the staged word. The operation-empty status (0x4, bit 0) reads 0 while a word is queued and returns to 1 once the sequencer has fetched it.
- R3: Operation code 0 with count 1 sets spi_cs_n to 1, and code 1 with count 1 sets it to 0. spi_cs_n changes at no other time.
- R4: Code 0x08 with count N sends N bytes taken from the data queue. Each byte goes MSB first in SPI mode 0: spi_sclk idles at 0, spi_mosi changes only while spi_sclk is low, each high and each low phase of spi_sclk lasts one clock, and every byte gives eight rising edges.
- R5: Code 0x0C with count N receives N bytes, sampling spi_miso on the rising edges (MSB first), and pushes each byte into the data queue. spi_mosi stays 0 during a receive run.
- R6: A transmit run that finds the data queue empty waits in state code 1 with spi_sclk at 0, and continues when a byte is written.
- R7: A receive run that finds the data queue full waits in state code 3 with spi_sclk at 0, and continues once a byte has been popped.
- R8: Both queues hold FIFO_DEPTH entries (16 by default). The full status bits (operation 0x5, data 0x7) read 1 when a queue is full. A push to a full queue is dropped, and a pop from an empty queue is ignored.
- R9: Writing 0x6 pushes bits [7:0] into the data queue. Register 0x9 shows the oldest byte. Writing 1 to 0x A pops it and exposes the next. The data-empty status is at 0x8, bit 0.
- R10: Operations are fetched only while bit 0 of the control register (0x0) is 1. When it is 0, queued words stay in the queue. The state code register (0x1) reads 0 when the sequencer is idle.
- R11: Unknown codes, code 0 or 1 with a count other than 1, and code 0x08 or 0x0C with count 0 are all fetched and discarded as no-ops. They produce no spi_sclk edge and no chip-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address, used for both writes and reads |
| reg_wdata | input | BUS_W | Register write data |
| reg_rdata | output | BUS_W | Registered read data for the address presented in the previous cycle |
| spi_sclk | output | 1 | Serial clock, half the system clock while shifting |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume that software never pushes into the data queue while a receive run is between its start and its push. They also assume that queue pops come only from the sequencer or the pop strobe, never from anywhere else. The stimulus keeps to this by waiting for the sequencer to report idle before it touches the data queue around receive runs. The only writes it makes during a run are the bytes a stalled transmit run needs, and the single pop that releases a stalled receive run. The bench holds the chip select low across all shifting, so its serial model counts every byte it sees.

// File: rtl/opseq_pkg.sv
package opseq_pkg;
  localparam int BYTE_W    = 8;
  localparam int OP_LEN_W  = 9;
  localparam int OP_CODE_W = 5;
  localparam int OP_W      = OP_LEN_W + OP_CODE_W;

  localparam logic [OP_CODE_W-1:0] CODE_CS_HIGH = 5'h00;
  localparam logic [OP_CODE_W-1:0] CODE_CS_LOW  = 5'h01;
  localparam logic [OP_CODE_W-1:0] CODE_TX      = 5'h08;
  localparam logic [OP_CODE_W-1:0] CODE_RX      = 5'h0C;

  localparam int RA_CTRL     = 0;
  localparam int RA_STATE    = 1;
  localparam int RA_OP_STAGE = 2;
  localparam int RA_OP_PUSH  = 3;
  localparam int RA_OP_EMPTY = 4;
  localparam int RA_OP_FULL  = 5;
  localparam int RA_D_WRITE  = 6;
  localparam int RA_D_FULL   = 7;
  localparam int RA_D_EMPTY  = 8;
  localparam int RA_D_HEAD   = 9;
  localparam int RA_D_POP    = 10;

  typedef enum logic [3:0] {
    SQ_IDLE     = 4'd0,
    SQ_TX_WAIT  = 4'd1,
    SQ_TX_SHIFT = 4'd2,
    SQ_RX_WAIT  = 4'd3,
    SQ_RX_SHIFT = 4'd4
  } sq_state_t;
endpackage

// File: rtl/opseq_fifo.sv
module opseq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto memory
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/opseq_shifter.sv
module opseq_shifter
  import opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

  logic              busy_q, done_q, sclk_q;
  logic [BC_W-1:0]   bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          tx_q   <= tx_byte;
          bit_q  <= '0;
        end
      end else if (!sclk_q) begin
        // rising edge: capture incoming bit
        sclk_q <= 1'b1;
        rx_q   <= {rx_q[BYTE_W-2:0], miso};
      end else begin
        // falling edge: advance outgoing bit
        sclk_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[BYTE_W-1];
endmodule

// File: rtl/opseq_sequencer.sv
module opseq_sequencer
  import opseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              man_en,
  input  logic              op_empty,
  input  logic [OP_W-1:0]   op_word,
  output logic              op_pop,
  input  logic              d_empty,
  input  logic              d_full,
  input  logic [BYTE_W-1:0] d_head,
  output logic              d_pop,
  output logic              d_push,
  output logic [BYTE_W-1:0] d_push_data,
  output logic              eng_start,
  output logic [BYTE_W-1:0] eng_tx,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx,
  output logic              cs_n,
  output logic [3:0]        state
);
  sq_state_t             st_q;
  logic [OP_LEN_W-1:0]   remain_q;
  logic                  cs_q;
  logic [OP_CODE_W-1:0]  code;
  logic [OP_LEN_W-1:0]   len;

  assign code        = op_word[OP_W-1:OP_LEN_W];
  assign len         = op_word[OP_LEN_W-1:0];
  assign op_pop      = (st_q == SQ_IDLE) && man_en && !op_empty;
  assign d_pop       = (st_q == SQ_TX_WAIT) && !d_empty;
  assign eng_start   = d_pop || ((st_q == SQ_RX_WAIT) && !d_full);
  assign eng_tx      = (st_q == SQ_TX_WAIT) ? d_head : '0;
  assign d_push      = (st_q == SQ_RX_SHIFT) && eng_done;
  assign d_push_data = eng_rx;
  assign cs_n        = cs_q;
  assign state       = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      remain_q <= '0;
      cs_q     <= 1'b1;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (op_pop) begin
            if (code == CODE_CS_HIGH && len == OP_LEN_W'(1)) begin
              cs_q <= 1'b1;
            end else if (code == CODE_CS_LOW && len == OP_LEN_W'(1)) begin
              cs_q <= 1'b0;
            end else if (code == CODE_TX && len != '0) begin
              st_q     <= SQ_TX_WAIT;
              remain_q <= len;
            end else if (code == CODE_RX && len != '0) begin
              st_q     <= SQ_RX_WAIT;
              remain_q <= len;
            end
          end
        end
        SQ_TX_WAIT:  if (!d_empty) st_q <= SQ_TX_SHIFT;
        SQ_TX_SHIFT: begin
          if (eng_done) begin
            remain_q <= remain_q - 1'b1;
            st_q     <= (remain_q == OP_LEN_W'(1)) ? SQ_IDLE : SQ_TX_WAIT;
          end
        end
        SQ_RX_WAIT:  if (!d_full) st_q <= SQ_RX_SHIFT;
        SQ_RX_SHIFT: begin
          if (eng_done) begin
            remain_q <= remain_q - 1'b1;
            st_q     <= (remain_q == OP_LEN_W'(1)) ? SQ_IDLE : SQ_RX_WAIT;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opseq_top.sv
module opseq_top
  import opseq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 4,
  parameter int BUS_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic              man_en_q;
  logic [OP_W-1:0]   op_stage_q;
  logic [BUS_W-1:0]  rdata_q;

  logic              op_push, op_pop, op_empty, op_full;
  logic [OP_W-1:0]   op_head;
  logic              sw_d_push, sw_d_pop, seq_d_push, seq_d_pop;
  logic              d_push, d_pop, d_empty, d_full;
  logic [BYTE_W-1:0] d_din, d_head, seq_push_data;
  logic              eng_start, eng_busy, eng_done;
  logic [BYTE_W-1:0] eng_tx, eng_rx;
  logic [3:0]        seq_state;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign op_push   = reg_we && hit(reg_addr, RA_OP_PUSH) && reg_wdata[0];
  assign sw_d_push = reg_we && hit(reg_addr, RA_D_WRITE);
  assign sw_d_pop  = reg_we && hit(reg_addr, RA_D_POP) && reg_wdata[0];

  // the sequencer's captured byte takes the write port over a software push
  assign d_push = seq_d_push || sw_d_push;
  assign d_din  = seq_d_push ? seq_push_data : reg_wdata[BYTE_W-1:0];
  assign d_pop  = seq_d_pop || sw_d_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      man_en_q   <= 1'b0;
      op_stage_q <= '0;
    end else if (reg_we) begin
      if (hit(reg_addr, RA_CTRL))     man_en_q   <= reg_wdata[0];
      if (hit(reg_addr, RA_OP_STAGE)) op_stage_q <= reg_wdata[OP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      if (hit(reg_addr, RA_CTRL))     rdata_q[0]          <= man_en_q;
      if (hit(reg_addr, RA_STATE))    rdata_q[3:0]        <= seq_state;
      if (hit(reg_addr, RA_OP_EMPTY)) rdata_q[0]          <= op_empty;
      if (hit(reg_addr, RA_OP_FULL))  rdata_q[0]          <= op_full;
      if (hit(reg_addr, RA_D_FULL))   rdata_q[0]          <= d_full;
      if (hit(reg_addr, RA_D_EMPTY))  rdata_q[0]          <= d_empty;
      if (hit(reg_addr, RA_D_HEAD))   rdata_q[BYTE_W-1:0] <= d_head;
    end
  end
  assign reg_rdata = rdata_q;

  opseq_fifo #(.WIDTH(OP_W), .DEPTH(FIFO_DEPTH)) op_q_i (
    .clk(clk), .rst(rst), .push(op_push), .din(op_stage_q),
    .pop(op_pop), .dout(op_head), .full(op_full), .empty(op_empty)
  );

  opseq_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) data_q_i (
    .clk(clk), .rst(rst), .push(d_push), .din(d_din),
    .pop(d_pop), .dout(d_head), .full(d_full), .empty(d_empty)
  );

  opseq_sequencer seq_i (
    .clk(clk), .rst(rst), .man_en(man_en_q),
    .op_empty(op_empty), .op_word(op_head), .op_pop(op_pop),
    .d_empty(d_empty), .d_full(d_full), .d_head(d_head),
    .d_pop(seq_d_pop), .d_push(seq_d_push), .d_push_data(seq_push_data),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done),
    .eng_rx(eng_rx), .cs_n(spi_cs_n), .state(seq_state)
  );

  opseq_shifter shift_i (
    .clk(clk), .rst(rst), .start(eng_start), .tx_byte(eng_tx),
    .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
    .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: rtl/opseq_checker.sv
module opseq_checker
  import opseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       sclk,
  input logic       mosi,
  input logic       cs_n,
  input logic [3:0] state,
  input logic       op_pop,
  input logic       man_en,
  input logic       d_full,
  input logic       d_empty
);
  assert_idle_sclk_low_R4: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE) |-> !sclk);

  assert_high_phase_one_clock_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |=> $fell(sclk));

  assert_mosi_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  assert_cs_moves_on_fetch_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> $past(op_pop));

  assert_tx_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_TX_WAIT && d_empty) |=> !sclk);

  assert_rx_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_RX_WAIT && d_full) |=> (!sclk && state == SQ_RX_WAIT));

  assert_no_fetch_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    !man_en |-> !op_pop);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(d_full && d_empty));
endmodule

bind opseq_top opseq_checker chk_i (
  .clk(clk), .rst(rst), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
  .state(seq_state), .op_pop(op_pop), .man_en(man_en_q),
  .d_full(d_full), .d_empty(d_empty)
);

// File: tb/opseq_top_tb_top.sv
module opseq_top_tb_top;
  localparam int ADDR_W = 4;
  localparam int BUS_W  = 16;
  localparam int DEPTH  = 16;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [BUS_W-1:0]  reg_wdata = '0;
  logic [BUS_W-1:0]  reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int n_chk = 0, n_fail = 0, cycles = 0;

  // serial slave model
  logic [7:0] resp [256];
  logic [7:0] cap  [256];
  logic [7:0] cap_sh = '0;
  int byte_cnt = 0, bit_cnt = 0, rises = 0;

  always #10 clk = ~clk;

  opseq_top #(.FIFO_DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  assign spi_miso = resp[byte_cnt & 255][3'(7 - bit_cnt)];

  always @(posedge spi_sclk) begin
    rises = rises + 1;
    if (!spi_cs_n) begin
      cap_sh = {cap_sh[6:0], spi_mosi};
      bit_cnt = bit_cnt + 1;
      if (bit_cnt == 8) begin
        cap[byte_cnt & 255] = cap_sh;
        byte_cnt = byte_cnt + 1;
        bit_cnt = 0;
      end
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles >= WATCHDOG) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = BUS_W'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = ADDR_W'(a);
    @(posedge clk);
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic push_op(input int code, input int len);
    wr(2, (code << 9) | (len & 511));
    wr(3, 1);
  endtask

  task automatic wait_idle();
    int e, s;
    do begin
      rd(4, e);
      rd(1, s);
    end while (!(e == 1 && s == 0));
  endtask

  task automatic idle_clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, base, len, r0;
    logic [7:0] tb_bytes [8];
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 256; i++) resp[i] = 8'($urandom);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 cs_n", int'(spi_cs_n), 1);
    chk_eq("R1 sclk", int'(spi_sclk), 0);
    chk_eq("R1 mosi", int'(spi_mosi), 0);
    rd(4, v); chk_eq("R1 op empty", v, 1);
    rd(5, v); chk_eq("R1 op full", v, 0);
    rd(8, v); chk_eq("R1 data empty", v, 1);
    rd(7, v); chk_eq("R1 data full", v, 0);
    rd(1, v); chk_eq("R1 state", v, 0);

    // R10 disabled sequencer keeps the word queued
    push_op(1, 1);
    idle_clocks(20);
    rd(4, v); chk_eq("R10 op kept while disabled", v, 0);
    chk_eq("R10 cs unchanged while disabled", int'(spi_cs_n), 1);
    wr(0, 1);
    wait_idle();
    rd(4, v); chk_eq("R2 op empty after fetch", v, 1);
    chk_eq("R3 cs low after code 1", int'(spi_cs_n), 0);

    // R4 directed transmit
    base = byte_cnt; r0 = rises;
    wr(6, 8'hA5); wr(6, 8'h3C);
    push_op(8, 2);
    wait_idle();
    chk_eq("R4 byte0", int'(cap[base & 255]), 8'hA5);
    chk_eq("R4 byte1", int'(cap[(base + 1) & 255]), 8'h3C);
    chk_eq("R4 rising edges", rises - r0, 16);

    // random mix of transmit and receive runs
    for (int it = 0; it < 12; it++) begin
      len = 1 + int'($urandom % 6);
      base = byte_cnt;
      if ($urandom % 2 == 1) begin
        for (int i = 0; i < len; i++) tb_bytes[i] = 8'($urandom);
        if ($urandom % 2 == 1) begin
          for (int i = 0; i < len; i++) wr(6, int'(tb_bytes[i]));
          push_op(8, len);
        end else begin
          push_op(8, len);
          idle_clocks(5);
          for (int i = 0; i < len; i++) wr(6, int'(tb_bytes[i]));
        end
        wait_idle();
        for (int i = 0; i < len; i++)
          chk_eq("R4 tx byte", int'(cap[(base + i) & 255]), int'(tb_bytes[i]));
      end else begin
        push_op(12, len);
        wait_idle();
        for (int i = 0; i < len; i++) begin
          rd(9, v);
          chk_eq("R5 rx byte", v, int'(resp[(base + i) & 255]));
          chk_eq("R5 mosi low", int'(cap[(base + i) & 255]), 0);
          wr(10, 1);
        end
        rd(8, v); chk_eq("R9 empty after pops", v, 1);
      end
    end

    // R6 transmit stall
    base = byte_cnt; r0 = rises;
    push_op(8, 1);
    idle_clocks(40);
    chk_eq("R6 no edges while stalled", rises - r0, 0);
    rd(1, v); chk_eq("R6 state code", v, 1);
    wr(6, 8'h81);
    wait_idle();
    chk_eq("R6 byte after stall", int'(cap[base & 255]), 8'h81);

    // R11 no-op codes
    r0 = rises;
    push_op(5'h1F, 3);
    push_op(0, 2);
    push_op(8, 0);
    push_op(12, 0);
    wait_idle();
    chk_eq("R11 no edges", rises - r0, 0);
    chk_eq("R11 cs kept low", int'(spi_cs_n), 0);

    // R8 / R9 data queue overflow and underflow
    for (int i = 0; i < DEPTH + 1; i++) wr(6, 8'h10 + i);
    rd(7, v); chk_eq("R8 data full", v, 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(9, v); chk_eq("R9 head order", v, 8'h10 + i);
      wr(10, 1);
    end
    rd(8, v); chk_eq("R8 extra push dropped", v, 1);
    wr(10, 1);
    wr(6, 8'h77);
    rd(9, v); chk_eq("R8 pop on empty ignored", v, 8'h77);
    rd(8, v); chk_eq("R8 not empty after push", v, 0);
    wr(10, 1);

    // R8 operation queue overflow
    wr(0, 0);
    base = byte_cnt;
    for (int i = 0; i < DEPTH + 1; i++) push_op(8, 1);
    rd(5, v); chk_eq("R8 op full", v, 1);
    wr(0, 1);
    for (int i = 0; i < DEPTH; i++) wr(6, 8'hC0 + i);
    wait_idle();
    chk_eq("R8 extra op dropped", byte_cnt - base, DEPTH);
    chk_eq("R8 last tx byte", int'(cap[(base + DEPTH - 1) & 255]), 8'hC0 + DEPTH - 1);

    // R7 receive stall on a full data queue
    for (int i = 0; i < DEPTH; i++) wr(6, 8'h40 + i);
    base = byte_cnt; r0 = rises;
    push_op(12, 1);
    idle_clocks(40);
    chk_eq("R7 no edges while full", rises - r0, 0);
    rd(1, v); chk_eq("R7 state code", v, 3);
    wr(10, 1);
    wait_idle();
    chk_eq("R7 edges after release", rises - r0, 8);
    for (int i = 1; i < DEPTH; i++) begin
      rd(9, v); chk_eq("R7 kept bytes", v, 8'h40 + i);
      wr(10, 1);
    end
    rd(9, v); chk_eq("R7 received byte", v, int'(resp[base & 255]));
    wr(10, 1);

    // R3 release, then R11 bad count on code 1
    push_op(0, 1);
    wait_idle();
    chk_eq("R3 cs high after code 0", int'(spi_cs_n), 1);
    push_op(1, 2);
    wait_idle();
    chk_eq("R11 code 1 count 2 ignored", int'(spi_cs_n), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule